// File: doc/BRIEF.md
# Set-Associative Tag Tracker

This block tracks which memory blocks a set-associative cache would hold. It stores tags and valid bits only. A byte address enters on a valid/ready handshake. The block splits the address into a byte offset, a set index and a tag, and compares the tag against every way of the chosen set. One cycle later it reports hit or miss and the way involved.

On a miss, the block writes the new tag into a way of that set. An empty way is always filled first. When the set is full, a run-time selector picks the victim policy: least recently used, oldest fill, or a way chosen by a free-running pseudo-random generator. The block keeps a running count of lookups and a running count of misses. A performance model or a cache controller can read both counts to measure hit rates.

Top module: `cache_tag_tracker`

## Requirements
- R1: The low log2(BLOCK_BYTES) address bits are the offset, the next log2(SETS) bits select the set, and the remaining upper bits are the tag. The offset never changes the outcome of a lookup.
- R2: A lookup is a hit only when a way of the selected set is valid and holds the same tag. `rsp_way` then gives that way.
- R3: On a miss in a set that still has an invalid way, the lowest-numbered invalid way is filled.
- R4: With `policy_sel` = 0 and the set full, the victim is the way whose last access, hit or fill, is the oldest.
- R5: With `policy_sel` = 1 and the set full, the victim is the way filled longest ago. Hits do not change this order.
- R6: With `policy_sel` = 2 or 3 and the set full, the victim comes from the low bits of a free-running LFSR that reset seeds with LFSR_SEED. Over several such misses the chosen way varies.
- R7: A miss writes the new tag into the victim way and marks it valid. A later lookup of the same block hits in that way.
- R8: `req_ready` is always high. Each accepted request gives exactly one `rsp_valid` pulse in the following cycle. A cycle with no request gives no response.
- R9: `access_count` rises by one for every accepted lookup. `miss_count` rises by one only for misses.
- R10: A synchronous reset invalidates every way, restarts the policy state and clears both counters and `rsp_valid`.
- R11: Sets are independent: a lookup or fill in one set never changes the outcome in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_addr | input | ADDR_W | Byte address to look up |
| policy_sel | input | 2 | Victim policy: 0 LRU, 1 FIFO, 2 or 3 random |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | 1 for a hit, 0 for a miss |
| rsp_way | output | log2(WAYS) | Way that hit or was filled |
| access_count | output | CNT_W | Lookups since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
A corrupted tag or valid bit shows up on the next lookup of the affected block. That lookup reports the wrong hit flag or way in the cycle right after it is accepted. Wrong replacement state stays hidden until a full set misses, so the bench fills every set and then forces misses under each policy. It checks the victim way against a reference model that uses access and fill timestamps. A miscounted lookup shows up in the counters in the response cycle of that same lookup.

// File: rtl/cache_tag_tracker.sv
module cache_tag_tracker #(
  parameter int ADDR_W      = 12,
  parameter int BLOCK_BYTES = 4,
  parameter int WAYS        = 4,
  parameter int CACHE_BYTES = 64,
  parameter int CNT_W       = 16,
  parameter logic [15:0] LFSR_SEED = 16'hACE1,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        policy_sel,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int SETS  = CACHE_BYTES / (BLOCK_BYTES * WAYS);
  localparam int OFF_W = $clog2(BLOCK_BYTES);
  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

  if (SETS < 2 || WAYS < 2 || (CACHE_BYTES % (BLOCK_BYTES * WAYS)) != 0 ||
      (1 << OFF_W) != BLOCK_BYTES || (1 << SET_W) != SETS ||
      (1 << WAY_W) != WAYS || TAG_W < 1) begin : g_bad_cfg
    $error("cache_tag_tracker: illegal geometry parameters");
  end

  logic [TAG_W-1:0] tag_q  [SETS][WAYS];
  logic [WAYS-1:0]  valid_q[SETS];
  logic [WAY_W-1:0] lru_q  [SETS][WAYS];
  logic [WAY_W-1:0] fifo_q [SETS][WAYS];
  logic [15:0]      lfsr_q;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic [WAYS-1:0]  hit_vec;
  logic [WAYS-1:0]  valid_row;
  logic             hit, any_free;
  logic [WAY_W-1:0] hit_way, free_way, lru_way, fifo_way, victim, sel_way;

  assign req_ready = 1'b1;
  assign set_idx   = req_addr[OFF_W +: SET_W];
  assign tag_in    = req_addr[ADDR_W-1 -: TAG_W];
  assign valid_row = valid_q[set_idx];
  assign hit       = |hit_vec;
  assign any_free  = ~&valid_row;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_row[w] && (tag_q[set_idx][w] == tag_in);
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    lru_way  = '0;
    fifo_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])                   hit_way  = WAY_W'(w);
      if (!valid_row[w])                free_way = WAY_W'(w);
      if (lru_q[set_idx][w] == OLDEST)  lru_way  = WAY_W'(w);
      if (fifo_q[set_idx][w] == OLDEST) fifo_way = WAY_W'(w);
    end
  end

  always_comb begin
    if (any_free)              victim = free_way;
    else if (policy_sel == 2'd0) victim = lru_way;
    else if (policy_sel == 2'd1) victim = fifo_way;
    else                       victim = lfsr_q[WAY_W-1:0];
  end

  assign sel_way = hit ? hit_way : victim;

  always_ff @(posedge clk) begin
    if (rst) lfsr_q <= LFSR_SEED;
    else     lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? 16'hB400 : 16'h0000);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tag_q[s][w]  <= '0;
          lru_q[s][w]  <= WAY_W'(w);
          fifo_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (req_valid) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == sel_way)
          lru_q[set_idx][w] <= '0;
        else if (lru_q[set_idx][w] < lru_q[set_idx][sel_way])
          lru_q[set_idx][w] <= lru_q[set_idx][w] + 1'b1;
      end
      if (!hit) begin
        tag_q[set_idx][victim]   <= tag_in;
        valid_q[set_idx][victim] <= 1'b1;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == victim)
            fifo_q[set_idx][w] <= '0;
          else if (fifo_q[set_idx][w] < fifo_q[set_idx][victim])
            fifo_q[set_idx][w] <= fifo_q[set_idx][w] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= '0;
      access_count <= '0;
      miss_count   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_hit      <= hit;
        rsp_way      <= sel_way;
        access_count <= access_count + 1'b1;
        if (!hit) miss_count <= miss_count + 1'b1;
      end
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R8
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R8
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $onehot0(hit_vec)); // R2
  AST_ACCESS_STEP: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> access_count == $past(access_count) + 1'b1); // R9
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> miss_count == $past(miss_count) + 1'b1); // R9
  AST_HIT_NO_MISS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> $stable(miss_count)); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && access_count == '0 && miss_count == '0)); // R10
endmodule

// File: tb/test_cache_tag_tracker.sv
module test_cache_tag_tracker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [11:0] req_addr = '0;
  logic [1:0]  policy_sel = 2'd0;
  logic        rsp_valid, rsp_hit;
  logic [1:0]  rsp_way;
  logic [15:0] access_count, miss_count;

  int checks = 0;
  int errors = 0;
  int mtag [4][4];
  bit mval [4][4];
  int muse [4][4];
  int mfill[4][4];
  int now, exp_acc, exp_miss;
  bit [3:0] rnd_seen;

  always #4 clk = ~clk;

  cache_tag_tracker i_cache_tag_tracker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .policy_sel(policy_sel), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .access_count(access_count),
    .miss_count(miss_count));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        mval[s][w] = 0; mtag[s][w] = 0; muse[s][w] = 0; mfill[s][w] = 0;
      end
    now = 1; exp_acc = 0; exp_miss = 0;
    chk(rsp_valid == 0, "R10 rsp_valid", rsp_valid, 0);
    chk(access_count == 0 && miss_count == 0, "R10 counters", access_count + miss_count, 0);
    chk(req_ready == 1, "R8 ready", req_ready, 1);
  endtask

  task automatic do_access(input int tag, input int set, input int off, input int pol);
    int ew, best;
    bit eh;
    req_valid = 1'b1;
    req_addr = {tag[7:0], set[1:0], off[1:0]};
    policy_sel = pol[1:0];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    eh = 0; ew = -1;
    for (int w = 0; w < 4; w++)
      if (mval[set][w] && mtag[set][w] == tag) begin eh = 1; ew = w; end
    if (!eh)
      for (int w = 3; w >= 0; w--) if (!mval[set][w]) ew = w;
    if (ew < 0) begin
      if (pol == 0) begin
        best = 0;
        for (int w = 1; w < 4; w++) if (muse[set][w] < muse[set][best]) best = w;
        ew = best;
      end else if (pol == 1) begin
        best = 0;
        for (int w = 1; w < 4; w++) if (mfill[set][w] < mfill[set][best]) best = w;
        ew = best;
      end else begin
        ew = int'(rsp_way);
        rnd_seen[ew] = 1'b1;
      end
    end
    exp_acc++;
    if (!eh) exp_miss++;
    chk(rsp_valid == 1, "R8 response pulse", rsp_valid, 1);
    chk(rsp_hit == eh, eh ? "R2 hit" : "R3/R7 miss", rsp_hit, eh);
    chk(int'(rsp_way) == ew,
        pol == 0 ? "R4 LRU way" : (pol == 1 ? "R5 FIFO way" : "R6 random way"),
        rsp_way, ew);
    chk(access_count == exp_acc, "R9 access count", access_count, exp_acc);
    chk(miss_count == exp_miss, "R9 miss count", miss_count, exp_miss);
    muse[set][ew] = now;
    if (!eh) begin
      mtag[set][ew] = tag; mval[set][ew] = 1; mfill[set][ew] = now;
    end
    now++;
  endtask

  task automatic idle_check();
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 0, "R8 idle no response", rsp_valid, 0);
  endtask

  task automatic fill_all(input int pol);
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++) do_access(16 + s * 4 + k, s, k, pol);
  endtask

  task automatic sweep(input int pol, input int n);
    for (int i = 0; i < n; i++)
      do_access((i * 7 + 3) % 6, (i * 5) % 4, i % 4, (pol == 2) ? 2 + (i % 2) : pol);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rnd_seen = '0;
    do_reset();
    idle_check();
    // R3 R1 R11 fill each set, then hits with varied offsets
    fill_all(0);
    for (int s = 0; s < 4; s++) begin
      do_access(16 + s * 4 + 2, s, 3, 0);
      do_access(16 + s * 4 + 0, s, 1, 0);
      do_access(16 + s * 4 + 3, s, 0, 0);
      do_access(16 + s * 4 + 1, s, 2, 0);
      do_access(200 + s, s, 0, 0); // R4: least recent is way 2
      do_access(200 + s, s, 3, 0); // R7: refilled block hits
    end
    idle_check();
    sweep(0, 240);

    do_reset();
    fill_all(1);
    for (int s = 0; s < 4; s++) begin
      do_access(16 + s * 4 + 0, s, 2, 1); // R5 hits leave fill order
      do_access(16 + s * 4 + 0, s, 1, 1);
      do_access(220 + s, s, 0, 1);        // replaces way 0
      do_access(230 + s, s, 0, 1);        // replaces way 1
    end
    sweep(1, 240);

    do_reset();
    fill_all(2);
    sweep(2, 240);
    chk($countones(rnd_seen) >= 2, "R6 victims vary", $countones(rnd_seen), 2);
    idle_check();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule